// File: doc/BRIEF.md
# Redundant Store Comparison Buffer

This block sits between a redundant pair of execution threads and the memory write path. The leading thread pushes each store it completes, address and data together, into an in-order queue. When the trailing thread later produces its copy of the same store, that copy is compared with the oldest queued entry. If address and data agree bit for bit, the leading copy is handed to memory through a valid/ready write port. If they disagree, no write happens and a fault flag is raised.

Only stores pass through this block. Other instructions are not checked. Only the leading copy ever reaches memory; the trailing copy is used for nothing but the comparison. When the queue is full, the leading thread is told to stall. Storage depth and the address and data widths are parameters. The default depth of 160 entries leaves room for the leading thread to run well ahead of the trailing one.

Top module: `store_compare_buffer`

## Requirements
- R1: After synchronous reset, `lead_full`, `mem_valid` and `fault` are 0, `trail_ready` is 1 and the queue is empty.
- R2: A trailing store accepted (`trail_valid` and `trail_ready` high at a clock edge) whose address and data both equal the oldest entry makes `mem_valid` high from the next cycle, with `mem_addr`/`mem_data` carrying the leading entry's values.
- R3: Entries reach memory in the order the leading thread pushed them.
- R4: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold, and `trail_ready` stays 0, so no further trailing store is taken.
- R5: `lead_full` is 1 exactly when DEPTH entries are held. A push while `lead_full` is 1 is dropped.
- R6: An entry leaves the queue only when its memory write handshake (`mem_valid` and `mem_ready` high) completes. `lead_full` falls in the cycle after the handshake that frees a slot from a full queue.
- R7: A difference in any address bit or any data bit sets `fault` from the next cycle. No memory write results, and the compared entry is discarded, so the next trailing store is compared with the following entry.
- R8: A trailing store accepted while the queue is empty sets `fault` and writes nothing. This includes the case where a leading push happens in the same cycle: that push is stored but is not compared in that cycle.
- R9: Once set, `fault` stays 1 until reset, and matching stores continue to be written.
- R10: A leading push and a handshake pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading thread presents a store |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store data |
| lead_full | output | 1 | Queue full; leading thread must stall |
| trail_valid | input | 1 | Trailing thread presents its copy of a store |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store data |
| trail_ready | output | 1 | Trailing store can be compared this cycle |
| mem_valid | output | 1 | Verified store offered to memory |
| mem_addr | output | ADDR_W | Verified store address |
| mem_data | output | DATA_W | Verified store data |
| mem_ready | input | 1 | Memory accepts the offered store |
| fault | output | 1 | Sticky mismatch or protocol-error flag |

## Verification
Two functions can fall in the same cycle: a leading push and the pop caused by a memory handshake, and a leading push and a trailing compare on an empty queue. The first is provoked by holding `mem_ready` low on a pending write, then raising it in the same cycle as a push. It is judged by whether the pushed entry is later written in order and whether one further trailing store finds the queue empty. The second is provoked by driving both ports in one cycle on an empty queue. It is judged by a raised fault with no write, followed by a normal write of the stored entry.

// File: rtl/scb_pkg.sv
package scb_pkg;
  // Outcome of presenting a trailing store to the head of the queue.
  typedef enum logic [1:0] {
    CMP_NONE     = 2'd0,
    CMP_MATCH    = 2'd1,
    CMP_MISMATCH = 2'd2,
    CMP_ORPHAN   = 2'd3
  } cmp_kind_e;
endpackage

// File: rtl/scb_store_ram.sv
module scb_store_ram #(
  parameter int DEPTH = 160,
  parameter int WIDTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/scb_occupancy.sv
module scb_occupancy #(
  parameter int DEPTH = 160,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count_next;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    unique case ({push, pop})
      2'b10:   count_next = count + 1'b1;
      2'b01:   count_next = count - 1'b1;
      default: count_next = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      full   <= 1'b0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count_next;
      full  <= (count_next == CAP);
    end
  end

  assign empty = (count == '0);
endmodule

// File: rtl/scb_matcher.sv
module scb_matcher #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                fire,
  input  logic                empty,
  input  logic [ADDR_W-1:0]   head_addr,
  input  logic [DATA_W-1:0]   head_data,
  input  logic [ADDR_W-1:0]   cmp_addr,
  input  logic [DATA_W-1:0]   cmp_data,
  output scb_pkg::cmp_kind_e  kind
);
  import scb_pkg::*;

  logic same;
  // Any differing bit in either field counts as a mismatch.
  assign same = ~|{head_addr ^ cmp_addr, head_data ^ cmp_data};

  always_comb begin
    if (!fire)      kind = CMP_NONE;
    else if (empty) kind = CMP_ORPHAN;
    else if (same)  kind = CMP_MATCH;
    else            kind = CMP_MISMATCH;
  end
endmodule

// File: rtl/store_compare_buffer.sv
module store_compare_buffer #(
  parameter int DEPTH  = 160,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lead_valid,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  output logic              lead_full,
  input  logic              trail_valid,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic [DATA_W-1:0] trail_data,
  output logic              trail_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              mem_ready,
  output logic              fault
);
  import scb_pkg::*;

  localparam int ENTRY_W = ADDR_W + DATA_W;
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);

  logic [PTR_W-1:0]   wr_ptr, rd_ptr;
  logic [CNT_W-1:0]   occ_count;
  logic               q_full, q_empty;
  logic [ENTRY_W-1:0] head_word;
  logic [ADDR_W-1:0]  head_addr;
  logic [DATA_W-1:0]  head_data;
  logic               push, pop, trail_fire, wr_done;
  cmp_kind_e          kind;

  logic               mem_valid_q, fault_q;
  logic [ADDR_W-1:0]  mem_addr_q;
  logic [DATA_W-1:0]  mem_data_q;

  assign push       = lead_valid && !q_full;
  assign trail_fire = trail_valid && trail_ready;
  assign wr_done    = mem_valid_q && mem_ready;
  assign pop        = wr_done || (kind == CMP_MISMATCH);

  scb_store_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata ({lead_addr, lead_data}),
    .raddr (rd_ptr),
    .rdata (head_word)
  );

  scb_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .count  (occ_count),
    .full   (q_full),
    .empty  (q_empty)
  );

  assign head_addr = head_word[ENTRY_W-1:DATA_W];
  assign head_data = head_word[DATA_W-1:0];

  scb_matcher #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .fire      (trail_fire),
    .empty     (q_empty),
    .head_addr (head_addr),
    .head_data (head_data),
    .cmp_addr  (trail_addr),
    .cmp_data  (trail_data),
    .kind      (kind)
  );

  // Output stage: one verified store in flight; head stays queued until written.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid_q <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      if (wr_done) mem_valid_q <= 1'b0;
      if (kind == CMP_MATCH) mem_valid_q <= 1'b1;
      if (kind == CMP_MISMATCH || kind == CMP_ORPHAN) fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (kind == CMP_MATCH) begin
      mem_addr_q <= head_addr;
      mem_data_q <= head_data;
    end
  end

  assign lead_full   = q_full;
  assign trail_ready = !mem_valid_q;
  assign mem_valid   = mem_valid_q;
  assign mem_addr    = mem_addr_q;
  assign mem_data    = mem_data_q;
  assign fault       = fault_q;
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int DEPTH  = 160,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              trail_valid,
  input logic              trail_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              fault,
  input logic [CNT_W-1:0]  occ
);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  p_orphan_fault_r8: assert property (@(posedge clk) disable iff (rst)
    trail_valid && trail_ready && occ == '0 |=> fault);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    occ <= CNT_W'(DEPTH));

  p_hold_entry_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> occ >= $past(occ));
endmodule

bind store_compare_buffer scb_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .trail_valid (trail_valid),
  .trail_ready (trail_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .fault       (fault),
  .occ         (occ_count)
);

// File: tb/tb_store_compare_buffer.sv
`timescale 1ns/1ps
module tb_store_compare_buffer;
  localparam int DEPTH = 160;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lead_valid = 1'b0, trail_valid = 1'b0, mem_ready = 1'b1;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0;
  logic [DW-1:0] lead_data = '0, trail_data = '0;
  logic lead_full, trail_ready, mem_valid, fault;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int nchk = 0, nerr = 0, nw = 0;
  logic [AW-1:0] wa [0:511];
  logic [DW-1:0] wd [0:511];

  always #2.5 clk = ~clk;

  store_compare_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data), .lead_full(lead_full),
    .trail_valid(trail_valid), .trail_addr(trail_addr), .trail_data(trail_data), .trail_ready(trail_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .fault(fault)
  );

  // Record every completed memory write.
  always @(posedge clk) begin
    if (!rst && mem_valid && mem_ready && nw < 512) begin
      wa[nw] = mem_addr;
      wd[nw] = mem_data;
      nw = nw + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lead_valid = 0; trail_valid = 0; mem_ready = 1;
    repeat (3) @(negedge clk);
    nw = 0;
    rst = 1'b0;
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    lead_valid = 1; lead_addr = a; lead_data = d;
    @(negedge clk);
    lead_valid = 0;
  endtask

  task automatic trail(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!trail_ready) @(negedge clk);
    trail_valid = 1; trail_addr = a; trail_data = d;
    @(negedge clk);
    trail_valid = 0;
  endtask

  function automatic logic [AW-1:0] badr(input int i); return 32'h1000 + i * 4; endfunction
  function automatic logic [DW-1:0] bdat(input int i); return 32'h5A5A0000 ^ i; endfunction

  task automatic t_reset();
    do_reset();
    chk("R1", "lead_full", lead_full, 0);
    chk("R1", "mem_valid", mem_valid, 0);
    chk("R1", "fault", fault, 0);
    chk("R1", "trail_ready", trail_ready, 1);
  endtask

  task automatic t_match_order();
    do_reset();
    push(32'hA0, 32'h11); push(32'hA4, 32'h22); push(32'hA8, 32'h33);
    trail(32'hA0, 32'h11);
    chk("R2", "mem_valid after match", mem_valid, 1);
    chk("R2", "mem_addr", mem_addr, 32'hA0);
    chk("R2", "mem_data", mem_data, 32'h11);
    trail(32'hA4, 32'h22); trail(32'hA8, 32'h33);
    repeat (2) @(negedge clk);
    chk("R3", "write count", nw, 3);
    chk("R3", "order 0", wa[0], 32'hA0);
    chk("R3", "order 1", wa[1], 32'hA4);
    chk("R3", "order 2 data", wd[2], 32'h33);
    chk("R2", "no fault", fault, 0);
  endtask

  task automatic t_backpressure();
    do_reset();
    push(32'hB0, 32'hBEEF);
    mem_ready = 0;
    trail(32'hB0, 32'hBEEF);
    for (int k = 0; k < 3; k++) begin
      trail_valid = 1; trail_addr = 32'hC0; trail_data = 32'h1;
      @(negedge clk);
      chk("R4", "held valid", mem_valid, 1);
      chk("R4", "held addr", mem_addr, 32'hB0);
      chk("R4", "trail_ready low", trail_ready, 0);
    end
    trail_valid = 0;
    mem_ready = 1;
    @(negedge clk);
    chk("R4", "one write", nw, 1);
    chk("R4", "no fault from blocked store", fault, 0);
    chk("R4", "valid dropped", mem_valid, 0);
  endtask

  task automatic t_mismatch();
    do_reset();
    push(32'hD0, 32'h10); push(32'hD4, 32'h20);
    trail(32'hD0, 32'h11);
    chk("R7", "data mismatch fault", fault, 1);
    chk("R7", "no write on mismatch", mem_valid, 0);
    trail(32'hD4, 32'h20);
    repeat (2) @(negedge clk);
    chk("R7", "next entry written", nw, 1);
    chk("R7", "next entry addr", wa[0], 32'hD4);
    do_reset();
    push(32'hE0, 32'h5);
    trail(32'hE0 ^ 32'h10, 32'h5);
    chk("R7", "addr mismatch fault", fault, 1);
    push(32'hE8, 32'h6);
    trail(32'hE8, 32'h6);
    repeat (2) @(negedge clk);
    chk("R9", "write continues after fault", nw, 1);
    chk("R9", "fault sticky", fault, 1);
  endtask

  task automatic t_orphan();
    do_reset();
    @(negedge clk);
    lead_valid = 1; lead_addr = 32'hF0; lead_data = 32'h77;
    trail_valid = 1; trail_addr = 32'hF0; trail_data = 32'h77;
    @(negedge clk);
    lead_valid = 0; trail_valid = 0;
    chk("R8", "orphan fault", fault, 1);
    chk("R8", "orphan no write", mem_valid, 0);
    trail(32'hF0, 32'h77);
    repeat (2) @(negedge clk);
    chk("R8", "same-cycle push kept", nw, 1);
  endtask

  task automatic t_full();
    int dead;
    do_reset();
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      lead_valid = 1; lead_addr = badr(i); lead_data = bdat(i);
      @(negedge clk);
    end
    lead_valid = 0;
    chk("R5", "full at DEPTH", lead_full, 1);
    push(32'hDEAD, 32'hDEAD);
    chk("R5", "still full after extra push", lead_full, 1);
    mem_ready = 0;
    trail(badr(0), bdat(0));
    @(negedge clk);
    chk("R6", "full held until handshake", lead_full, 1);
    mem_ready = 1;
    @(negedge clk);
    chk("R6", "full drops after handshake", lead_full, 0);
    for (int i = 1; i < DEPTH; i++) trail(badr(i), bdat(i));
    repeat (2) @(negedge clk);
    chk("R5", "drained writes", nw, DEPTH);
    chk("R3", "last entry addr", wa[DEPTH-1], badr(DEPTH-1));
    dead = 0;
    for (int i = 0; i < DEPTH; i++) if (wa[i] == 32'hDEAD) dead++;
    chk("R5", "dropped push not written", dead, 0);
    chk("R5", "no fault while draining", fault, 0);
    trail(32'hDEAD, 32'hDEAD);
    chk("R5", "queue empty after drain", fault, 1);
  endtask

  task automatic t_simul();
    do_reset();
    push(32'h200, 32'hAA);
    mem_ready = 0;
    trail(32'h200, 32'hAA);
    lead_valid = 1; lead_addr = 32'h204; lead_data = 32'hBB; mem_ready = 1;
    @(negedge clk);
    lead_valid = 0;
    chk("R10", "pop in push cycle", nw, 1);
    trail(32'h204, 32'hBB);
    repeat (2) @(negedge clk);
    chk("R10", "pushed entry written", nw, 2);
    chk("R10", "pushed entry addr", wa[1], 32'h204);
    chk("R10", "no fault", fault, 0);
    trail(32'h204, 32'hBB);
    chk("R10", "count back to empty", fault, 1);
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset();
    t_match_order();
    t_backpressure();
    t_mismatch();
    t_orphan();
    t_full();
    t_simul();
    summary();
  end
endmodule